// File: doc/BRIEF.md
# Multiplexed Address/Data Register Bus Front End

This block gives a host processor access to a small register file over eight shared address/data lines. A bus cycle first presents an address, which the block captures when the address-latch strobe falls. The same lines then carry write data from the host, or read data from the block. A strap input picks one of two strobe conventions. In the first, active-low read and write strobes are separate. In the second, an active-high data strobe is paired with a read/write direction line.

All strobes and the bus lines enter a fast system clock through multi-stage synchronisers, and the block acts on the edges it detects there. The register file holds eight read/write setup bytes, an interrupt mask byte and a test byte. Its read-only window shows twelve counter and pattern bytes and a status byte, which the surrounding datapath supplies as plain inputs.

The bus is split into an input, an output and an output enable, so the pad ring forms the tri-state driver. Every read/write byte also appears on an output port for the datapath.

Top module: `mux_regbus_if`

## Requirements
- R1: With `mode_sel` = 0, a read is active while `rd_n` is low and a write is active while `wr_n` is low. `ds` and `rw` have no effect on the registers or on `ad_oe`.
- R2: With `mode_sel` = 1, a read is active while `ds` = 1 and `rw` = 1, and a write is active while `ds` = 1 and `rw` = 0. `rd_n` and `wr_n` have no effect.
- R3: The address is the value on `ad_in` during the last part of the `ale` high pulse. It is taken when `ale` falls and is decoded on all eight bits.
- R4: A write commits when the write strobe ends, using the `ad_in` value from the end of the strobe. It lands only at a read/write address: 0x00–0x07, 0x15 or 0x1C.
- R5: A write to a read-only address (0x08–0x14) or to any unmapped address changes no register.
- R6: A read returns the addressed byte. Address 0x00 gives `pat_set[31:24]` and 0x03 gives `pat_set[7:0]`. 0x04 gives `pat_len`, 0x05 `poly_tap`, 0x06 `pat_ctrl`, 0x07 `err_ins`, 0x15 `irq_mask` and 0x1C `test_reg`. Addresses 0x08–0x0B give `cnt_bits` with the most significant byte first, 0x0C–0x0F give `cnt_errs` the same way, 0x10–0x13 give `rx_pattern` the same way, and 0x14 gives `status_in`. Every other address reads 0x00.
- R7: `ad_oe` is high only while a read strobe is active, at least one address has been latched since reset, and `ale` is low. It drops after the read strobe ends (`rd_n` rising, or `ds` falling).
- R8: A synchronous reset clears every read/write register to 0x00, forgets the latched address and holds `ad_oe` low.
- R9: The test byte at 0x1C can be written and read back, and it resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Strobe convention strap: 0 = separate read/write strobes, 1 = data strobe plus direction line |
| ale | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low (mode 0) |
| wr_n | input | 1 | Write strobe, active low (mode 0) |
| ds | input | 1 | Data strobe, active high (mode 1) |
| rw | input | 1 | Direction line: 1 = read, 0 = write (mode 1) |
| ad_in | input | 8 | Shared address/data lines, input side |
| ad_out | output | 8 | Read data for the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| cnt_bits | input | 32 | Bit counter value (read-only window) |
| cnt_errs | input | 32 | Error counter value (read-only window) |
| rx_pattern | input | 32 | Received pattern value (read-only window) |
| status_in | input | 8 | Status byte (read-only window) |
| pat_set | output | 32 | Pattern set bytes 0x00–0x03 |
| pat_len | output | 8 | Pattern length byte |
| poly_tap | output | 8 | Polynomial tap byte |
| pat_ctrl | output | 8 | Pattern control byte |
| err_ins | output | 8 | Error insert byte |
| irq_mask | output | 8 | Interrupt mask byte |
| test_reg | output | 8 | Test byte |

## Verification
The assertions assume a well-formed host. Each strobe stays at one level for at least a few system clocks, `ad_in` is stable whenever the synchroniser samples it near a strobe edge, and a read or write strobe is never active while `ale` is high. The bench drives every phase for four to six clocks. It changes `ad_in` only while no strobe is active, and it raises a read strobe during `ale` only in the one deliberate case that checks the address-phase release. Cross-mode stimulus, such as data-strobe pulses in mode 0, is applied on purpose, and the bench checks for it only at the ports.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

   typedef enum logic {
      BUS_SEP_STROBE  = 1'b0,
      BUS_DATA_STROBE = 1'b1
   } bus_mode_e;

   localparam int unsigned NUM_RW_SLOTS = 10;
   localparam int unsigned NUM_RO_BYTES = 13;
   localparam int unsigned RO_BASE      = 'h08;
   localparam int unsigned MASK_ADDR    = 'h15;
   localparam int unsigned TEST_ADDR    = 'h1C;

   // address owned by a writable storage slot
   function automatic int unsigned slot_addr(input int unsigned s);
      if (s < 8)       return s;
      else if (s == 8) return MASK_ADDR;
      else             return TEST_ADDR;
   endfunction

endpackage

// File: rtl/mbr_sync.sv
module mbr_sync #(
   parameter int unsigned   WIDTH   = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mbr_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst)         stg[g] <= RST_VAL;
            else if (g == 0) stg[g] <= d;
            else             stg[g] <= stg[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/mbr_strobe.sv
module mbr_strobe
   import mbr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_sel,
   input  logic              ale_s,
   input  logic              rd_n_s,
   input  logic              wr_n_s,
   input  logic              ds_s,
   input  logic              rw_s,
   input  logic [DATA_W-1:0] bus_s,
   output logic              rd_act,
   output logic              ale_act,
   output logic              wr_commit,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] addr_q,
   output logic              addr_vld
);

   logic              wr_act;
   logic              ale_prev;
   logic              wr_prev;
   logic [DATA_W-1:0] addr_hold;

   // strobe convention chosen by the strap
   always_comb begin
      if (mode_sel == BUS_DATA_STROBE) begin
         rd_act = ds_s & rw_s;
         wr_act = ds_s & ~rw_s;
      end else begin
         rd_act = ~rd_n_s;
         wr_act = ~wr_n_s;
      end
      ale_act = ale_s;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ale_prev  <= 1'b0;
         wr_prev   <= 1'b0;
         addr_hold <= '0;
         addr_q    <= '0;
         addr_vld  <= 1'b0;
         wdata     <= '0;
      end else begin
         ale_prev <= ale_s;
         wr_prev  <= wr_act;
         if (ale_s)  addr_hold <= bus_s;
         if (wr_act) wdata     <= bus_s;
         if (ale_prev && !ale_s) begin
            addr_q   <= addr_hold;
            addr_vld <= 1'b1;
         end
      end
   end

   assign wr_commit = wr_prev & ~wr_act & addr_vld;

   // R3: falling address strobe takes the last value seen while it was high
   p_addr_latch_r3 : assert property (@(posedge clk) disable iff (rst)
      (ale_prev && !ale_s) |=> (addr_vld && addr_q == $past(addr_hold)));

   // R4: a commit only follows a write strobe that was active
   p_commit_after_strobe_r4 : assert property (@(posedge clk) disable iff (rst)
      wr_commit |-> $past(wr_act));

endmodule

// File: rtl/mbr_regs.sv
module mbr_regs
   import mbr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [DATA_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_RO_BYTES*DATA_W-1:0] ro_vec,
   output logic [NUM_RW_SLOTS*DATA_W-1:0] rw_vec,
   output logic [DATA_W-1:0]              rdata
);

   logic [DATA_W-1:0]       rw_q [NUM_RW_SLOTS];
   logic [NUM_RW_SLOTS-1:0] slot_hit;

   generate
      for (genvar g = 0; g < NUM_RW_SLOTS; g++) begin : g_slot
         localparam logic [DATA_W-1:0] SA = DATA_W'(slot_addr(g));
         assign slot_hit[g] = (addr == SA);
         always_ff @(posedge clk) begin
            if (rst)                     rw_q[g] <= '0;
            else if (wr_en && slot_hit[g]) rw_q[g] <= wdata;
         end
         assign rw_vec[g*DATA_W +: DATA_W] = rw_q[g];

         // R4: a write to this slot's address lands with the committed data
         p_write_lands_r4 : assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == SA) |=> (rw_q[g] == $past(wdata)));
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int s = 0; s < NUM_RW_SLOTS; s++)
         if (slot_hit[s]) rdata = rw_q[s];
      for (int k = 0; k < NUM_RO_BYTES; k++)
         if (addr == DATA_W'(RO_BASE + k)) rdata = ro_vec[k*DATA_W +: DATA_W];
   end

   // R5: writes outside the writable set leave every slot untouched
   p_ro_write_ignored_r5 : assert property (@(posedge clk) disable iff (rst)
      (wr_en && slot_hit == '0) |=> $stable(rw_vec));

endmodule

// File: rtl/mux_regbus_if.sv
module mux_regbus_if
   import mbr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mode_sel,
   input  logic                ale,
   input  logic                rd_n,
   input  logic                wr_n,
   input  logic                ds,
   input  logic                rw,
   input  logic [DATA_W-1:0]   ad_in,
   output logic [DATA_W-1:0]   ad_out,
   output logic                ad_oe,
   input  logic [4*DATA_W-1:0] cnt_bits,
   input  logic [4*DATA_W-1:0] cnt_errs,
   input  logic [4*DATA_W-1:0] rx_pattern,
   input  logic [DATA_W-1:0]   status_in,
   output logic [4*DATA_W-1:0] pat_set,
   output logic [DATA_W-1:0]   pat_len,
   output logic [DATA_W-1:0]   poly_tap,
   output logic [DATA_W-1:0]   pat_ctrl,
   output logic [DATA_W-1:0]   err_ins,
   output logic [DATA_W-1:0]   irq_mask,
   output logic [DATA_W-1:0]   test_reg
);

   localparam int unsigned STRB_W = 5;
   localparam logic [STRB_W-1:0] STRB_IDLE = 5'b01100; // ale, rd_n, wr_n, ds, rw

   generate
      if (DATA_W < 6) begin : g_bad_width
         $error("bus width too small for the address map");
      end
   endgenerate

   logic [STRB_W-1:0] strb_s;
   logic [DATA_W-1:0] bus_s;

   mbr_sync #(.WIDTH(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL(STRB_IDLE)) u_sync_strb (
      .clk(clk), .rst(rst), .d({ale, rd_n, wr_n, ds, rw}), .q(strb_s));

   mbr_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst(rst), .d(ad_in), .q(bus_s));

   logic              rd_act, ale_act, wr_commit, addr_vld;
   logic [DATA_W-1:0] wdata, addr_q, rdata;

   mbr_strobe #(.DATA_W(DATA_W)) u_strobe (
      .clk(clk), .rst(rst), .mode_sel(mode_sel),
      .ale_s(strb_s[4]), .rd_n_s(strb_s[3]), .wr_n_s(strb_s[2]),
      .ds_s(strb_s[1]), .rw_s(strb_s[0]), .bus_s(bus_s),
      .rd_act(rd_act), .ale_act(ale_act), .wr_commit(wr_commit),
      .wdata(wdata), .addr_q(addr_q), .addr_vld(addr_vld));

   logic [NUM_RO_BYTES*DATA_W-1:0] ro_vec;
   logic [NUM_RW_SLOTS*DATA_W-1:0] rw_vec;

   // read-only window: each 32-bit value most significant byte first
   generate
      for (genvar k = 0; k < 4; k++) begin : g_ro
         assign ro_vec[k*DATA_W +: DATA_W]     = cnt_bits[(3-k)*DATA_W +: DATA_W];
         assign ro_vec[(k+4)*DATA_W +: DATA_W] = cnt_errs[(3-k)*DATA_W +: DATA_W];
         assign ro_vec[(k+8)*DATA_W +: DATA_W] = rx_pattern[(3-k)*DATA_W +: DATA_W];
         assign pat_set[(3-k)*DATA_W +: DATA_W] = rw_vec[k*DATA_W +: DATA_W];
      end
   endgenerate
   assign ro_vec[12*DATA_W +: DATA_W] = status_in;

   mbr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_commit), .addr(addr_q), .wdata(wdata),
      .ro_vec(ro_vec), .rw_vec(rw_vec), .rdata(rdata));

   assign pat_len  = rw_vec[4*DATA_W +: DATA_W];
   assign poly_tap = rw_vec[5*DATA_W +: DATA_W];
   assign pat_ctrl = rw_vec[6*DATA_W +: DATA_W];
   assign err_ins  = rw_vec[7*DATA_W +: DATA_W];
   assign irq_mask = rw_vec[8*DATA_W +: DATA_W];
   assign test_reg = rw_vec[9*DATA_W +: DATA_W];

   logic              oe_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         oe_q    <= rd_act & addr_vld & ~ale_act;
         rdata_q <= rdata;
      end
   end

   assign ad_oe  = oe_q;
   assign ad_out = rdata_q;

   // R7: drive only after an active read outside the address phase
   p_oe_needs_read_r7 : assert property (@(posedge clk) disable iff (rst)
      ad_oe |-> ($past(rd_act) && !$past(ale_act)));

   // R7: release follows the end of the read strobe
   p_oe_release_r7 : assert property (@(posedge clk) disable iff (rst)
      !rd_act |=> !ad_oe);

   // R8: leaving reset the bus is not driven
   p_reset_quiet_r8 : assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !ad_oe);

endmodule

// File: tb/mux_regbus_if_tb_top.sv
module mux_regbus_if_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst = 1'b1;
   logic        mode_sel = 1'b0;
   logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, ds = 1'b0, rw = 1'b0;
   logic [7:0]  ad_in = 8'h00;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [31:0] cnt_bits   = 32'h1122_3344;
   logic [31:0] cnt_errs   = 32'h5566_7788;
   logic [31:0] rx_pattern = 32'h99AA_BBCC;
   logic [7:0]  status_in  = 8'hD7;
   logic [31:0] pat_set;
   logic [7:0]  pat_len, poly_tap, pat_ctrl, err_ins, irq_mask, test_reg;

   mux_regbus_if dut_i (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .ds(ds), .rw(rw), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .cnt_bits(cnt_bits), .cnt_errs(cnt_errs),
      .rx_pattern(rx_pattern), .status_in(status_in), .pat_set(pat_set),
      .pat_len(pat_len), .poly_tap(poly_tap), .pat_ctrl(pat_ctrl),
      .err_ins(err_ins), .irq_mask(irq_mask), .test_reg(test_reg));

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mdl [256];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit is_rw(input int a);
      return (a <= 7) || a == 'h15 || a == 'h1C;
   endfunction

   function automatic logic [7:0] exp_rd(input int a);
      if (is_rw(a))             return mdl[a];
      if (a >= 8 && a <= 11)    return cnt_bits[(11-a)*8 +: 8];
      if (a >= 12 && a <= 15)   return cnt_errs[(15-a)*8 +: 8];
      if (a >= 16 && a <= 19)   return rx_pattern[(19-a)*8 +: 8];
      if (a == 20)              return status_in;
      return 8'h00;
   endfunction

   task automatic reset_model();
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
   endtask

   task automatic addr_phase(input logic [7:0] a);
      ad_in = a; ale = 1'b1; step(4);
      ale = 1'b0; step(4);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      addr_phase(a);
      ad_in = d;
      if (mode_sel) begin rw = 1'b0; step(1); ds = 1'b1; end
      else wr_n = 1'b0;
      step(5);
      if (mode_sel) ds = 1'b0; else wr_n = 1'b1;
      step(5);
      ad_in = 8'h3E;
      if (is_rw(a)) mdl[a] = d;
   endtask

   task automatic do_read(input logic [7:0] a, input string tag);
      addr_phase(a);
      ad_in = 8'hC3;
      if (mode_sel) begin rw = 1'b1; step(1); ds = 1'b1; end
      else rd_n = 1'b0;
      step(6);
      chk({tag, " R7 oe during read"}, ad_oe, 1);
      chk({tag, " R6 read data"}, ad_out, exp_rd(a));
      if (mode_sel) ds = 1'b0; else rd_n = 1'b1;
      step(6);
      chk({tag, " R7 oe released"}, ad_oe, 0);
      rw = 1'b0;
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " pat_set"}, pat_set, {mdl[0], mdl[1], mdl[2], mdl[3]});
      chk({tag, " pat_len"}, pat_len, mdl[4]);
      chk({tag, " poly_tap"}, poly_tap, mdl[5]);
      chk({tag, " pat_ctrl"}, pat_ctrl, mdl[6]);
      chk({tag, " err_ins"}, err_ins, mdl[7]);
      chk({tag, " irq_mask"}, irq_mask, mdl['h15]);
      chk({tag, " test_reg"}, test_reg, mdl['h1C]);
   endtask

   bit done = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      reset_model();
      step(5);
      chk("R8 oe in reset", ad_oe, 0);
      chk_outs("R8 reset");
      rst = 1'b0;
      step(3);

      // R7: no address latched yet, read strobe must not drive
      rd_n = 1'b0; step(6);
      chk("R7 no address yet", ad_oe, 0);
      rd_n = 1'b1; step(4);

      // R4 R5 R6 R1 R2: full sweep of the low address space in both modes
      for (int m = 0; m < 2; m++) begin
         mode_sel = m[0];
         step(4);
         for (int a = 0; a < 32; a++)
            do_write(8'(a), 8'((a * 29 + m * 77) ^ 8'hA5));
         do_write(8'hFF, 8'h5F);
         do_write(8'h9C, 8'h61);
         chk_outs(m == 0 ? "R1 R4 R5 sweep mode0" : "R2 R4 R5 sweep mode1");
         for (int a = 0; a < 32; a++)
            do_read(8'(a), m == 0 ? "R1 sweep" : "R2 sweep");
         do_read(8'hFF, "R6 unmapped high");
         do_read(8'h9C, "R3 full decode");
      end

      // R1: data-strobe signalling has no effect in mode 0
      mode_sel = 1'b0; step(4);
      addr_phase(8'h04);
      ad_in = 8'hEE; rw = 1'b0; ds = 1'b1; step(6); ds = 1'b0; step(6);
      chk("R1 ds write ignored", pat_len, mdl[4]);
      rw = 1'b1; ds = 1'b1; step(6);
      chk("R1 ds read ignored", ad_oe, 0);
      ds = 1'b0; rw = 1'b0; step(4);

      // R2: separate strobes have no effect in mode 1
      mode_sel = 1'b1; step(4);
      addr_phase(8'h05);
      ad_in = 8'h12; wr_n = 1'b0; step(6); wr_n = 1'b1; step(6);
      chk("R2 wr_n ignored", poly_tap, mdl[5]);
      rd_n = 1'b0; step(6);
      chk("R2 rd_n ignored", ad_oe, 0);
      rd_n = 1'b1; step(4);

      // R7: address phase forces release
      mode_sel = 1'b0; step(4);
      addr_phase(8'h06);
      rd_n = 1'b0; step(6);
      chk("R7 read drives", ad_oe, 1);
      ale = 1'b1; step(5);
      chk("R7 released during ale", ad_oe, 0);
      rd_n = 1'b1; step(2); ale = 1'b0; step(4);

      // R9 R8: test byte and reset clearing
      do_write(8'h1C, 8'h3C);
      chk("R9 test byte written", test_reg, 8'h3C);
      do_read(8'h1C, "R9 test byte");
      rst = 1'b1; step(4);
      reset_model();
      chk_outs("R8 second reset");
      chk("R8 oe held low", ad_oe, 0);
      rst = 1'b0; step(3);
      do_read(8'h1C, "R9 test byte after reset");
      do_read(8'h14, "R6 status");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule